// File: doc/BRIEF.md
# Stretched Inter-Frame Gap Timer

This block sits beside a full-duplex Ethernet transmitter and decides when the next frame may begin. It counts every byte the transmitter sends, preamble included, and at the end of each frame it works out how long the line must stay idle before the next frame may start. By default that idle time is the standard minimum of 96 bit times. When stretching is switched on and the link is full duplex, the idle time instead scales with the length of the frame just sent. That length is multiplied by one byte of a 16-bit ratio setting and divided by the other byte plus one. The result is never allowed below the minimum.

All lengths and gaps are in byte times, and one clock cycle is one byte time, so the minimum gap is 12 cycles. The division uses an iterative restoring divider that starts at end of frame and needs 24 cycles. In stretched mode the next frame is held off until the quotient is known and the computed gap has elapsed. Mode, enable and ratio are captured at end of frame. The only flow control is `tx_ready`, a level that grants permission to start a frame. There is no data stream through the block, so there is no valid/ready handshake. The transmitter is expected to begin a frame only while `tx_ready` is high.

Top module: `ipg_stretch`

## Requirements
- R1: After reset `tx_ready` is high, because there is no earlier frame to space from.
- R2: `tx_ready` is low in the cycle after the cycle in which `frame_end` is high.
- R3: If `stretch_en` or `full_duplex` is low at end of frame, `tx_ready` stays low for exactly 12 cycles after the `frame_end` cycle, whatever the ratio holds.
- R4: The frame length is the count of cycles with `byte_vld` high since the previous `frame_end`, including a strobe in the `frame_end` cycle itself. Preamble bytes are strobed and counted like any other byte.
- R5: With stretching active, the gap G is floor(L × ratio[7:0] / (ratio[15:8] + 1)) byte times. The low byte is the multiplier and the high byte is the divisor less one.
- R6: With stretching active, a computed gap below 12 is raised to 12.
- R7: With stretching active, `tx_ready` stays low for max(G', 24) cycles after the `frame_end` cycle, where G' is the gap after the R6 clamp and 24 is the divider latency.
- R8: A high ratio byte of zero divides by one, so G = L × ratio[7:0].
- R9: `stretch_en`, `full_duplex` and `ratio` are captured in the `frame_end` cycle. Changes during the gap affect only the next gap.
- R10: The length count saturates at 65535 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one byte time per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | One transmitted byte in this cycle, preamble included |
| frame_end | input | 1 | Last byte of the current frame is in this cycle |
| stretch_en | input | 1 | Enable for length-scaled gaps |
| full_duplex | input | 1 | Link is in full-duplex mode |
| ratio | input | 16 | [7:0] multiplier, [15:8] divisor minus one |
| tx_ready | output | 1 | Next frame may start |

## Verification
The hardest state to reach from the ports is length saturation. Reaching it needs a frame longer than 65535 bytes, and the ratio must be chosen so that a saturated count and a wrapped count give clearly different gaps. The bench streams a 66000-byte frame with a divisor of 256, so saturation yields a 255-cycle gap while wrap-around would yield the 24-cycle divider floor. The second hard case is a ratio and mode change in the middle of a running gap. The bench rewrites both a few cycles into a long stretched gap, then checks that the current gap keeps its length and that the following frame picks up the new setting.

// File: rtl/ipg_pkg.sv
package ipg_pkg;
  localparam int unsigned MIN_GAP_BYTES = 12;

  function automatic logic [23:0] clamp_min(input logic [23:0] v, input logic [23:0] lo);
    return (v < lo) ? lo : v;
  endfunction
endpackage

// File: rtl/ipg_len_counter.sv
module ipg_len_counter #(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic             clear,
  output logic [LEN_W-1:0] len_total
);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic [LEN_W-1:0] cnt_q;

  // total including a byte strobed in the current cycle
  always_comb begin
    if (cnt_q == LEN_MAX) len_total = LEN_MAX;
    else                  len_total = cnt_q + LEN_W'(byte_vld);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else            cnt_q <= len_total;
  end

  a_r10_len_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LEN_MAX && !clear) |=> (cnt_q == LEN_MAX))
    else $error("length counter wrapped");

  a_r4_len_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0))
    else $error("length not cleared at frame end");
endmodule

// File: rtl/ipg_ratio_div.sv
module ipg_ratio_div #(
  parameter int unsigned DVD_W = 24,
  parameter int unsigned DVS_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic [DVD_W-1:0] quotient,
  output logic             valid
);
  localparam int unsigned CNT_W = $clog2(DVD_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DVD_W - 1);

  logic [DVD_W-1:0] quo_q;
  logic [DVS_W-1:0] dvs_q;
  logic [DVS_W:0]   rem_q, rem_sh, rem_nx;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, valid_q, ge;

  always_comb begin
    rem_sh = {rem_q[DVS_W-1:0], quo_q[DVD_W-1]};
    ge     = (rem_sh >= {1'b0, dvs_q});
    rem_nx = ge ? (rem_sh - {1'b0, dvs_q}) : rem_sh;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quo_q   <= '0;
      dvs_q   <= '0;
      rem_q   <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      valid_q <= 1'b0;
    end else if (start) begin
      quo_q   <= dividend;
      dvs_q   <= divisor;
      rem_q   <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b1;
      valid_q <= 1'b0;
    end else if (run_q) begin
      quo_q <= {quo_q[DVD_W-2:0], ge};
      rem_q <= rem_nx;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        run_q   <= 1'b0;
        valid_q <= 1'b1;
      end
    end
  end

  assign quotient = quo_q;
  assign valid    = valid_q;

  a_r5_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (rem_q < {1'b0, dvs_q}))
    else $error("remainder not reduced");

  a_r7_start_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !valid_q)
    else $error("stale quotient after restart");
endmodule

// File: rtl/ipg_gap_timer.sv
module ipg_gap_timer
  import ipg_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             fixed_in,
  input  logic [CNT_W-1:0] quotient,
  input  logic             q_valid,
  output logic             ready,
  output logic [CNT_W-1:0] elapsed
);
  localparam logic [CNT_W-1:0] MIN_GAP = CNT_W'(MIN_GAP_BYTES);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             busy_q, fixed_q, done;
  logic [CNT_W-1:0] cnt_q, target;

  always_comb begin
    target = fixed_q ? MIN_GAP : ((quotient < MIN_GAP) ? MIN_GAP : quotient);
    done   = busy_q && (fixed_q || q_valid) && (cnt_q >= target);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      fixed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      fixed_q <= fixed_in;
      cnt_q   <= '0;
    end else if (busy_q) begin
      if (done) busy_q <= 1'b0;
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready   = !busy_q || done;
  assign elapsed = cnt_q;

  a_r3_fixed_not_early: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && fixed_q && !start) |=> (busy_q || (cnt_q >= MIN_GAP)))
    else $error("fixed gap ended early");
endmodule

// File: rtl/ipg_stretch.sv
module ipg_stretch
  import ipg_pkg::*;
#(
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned RATIO_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 byte_vld,
  input  logic                 frame_end,
  input  logic                 stretch_en,
  input  logic                 full_duplex,
  input  logic [2*RATIO_W-1:0] ratio,
  output logic                 tx_ready
);
  localparam int unsigned PROD_W = LEN_W + RATIO_W;
  localparam int unsigned DVS_W  = RATIO_W + 1;

  logic [LEN_W-1:0]  len_total;
  logic [PROD_W-1:0] product, quotient, elapsed;
  logic [DVS_W-1:0]  divisor;
  logic              stretch_now, q_valid;

  assign stretch_now = stretch_en && full_duplex;
  assign product     = PROD_W'(len_total) * PROD_W'(ratio[RATIO_W-1:0]);
  assign divisor     = {1'b0, ratio[2*RATIO_W-1:RATIO_W]} + 1'b1;

  ipg_len_counter #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .clear(frame_end),
    .len_total(len_total)
  );

  ipg_ratio_div #(.DVD_W(PROD_W), .DVS_W(DVS_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(frame_end && stretch_now),
    .dividend(product), .divisor(divisor), .quotient(quotient), .valid(q_valid)
  );

  ipg_gap_timer #(.CNT_W(PROD_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .start(frame_end), .fixed_in(!stretch_now),
    .quotient(quotient), .q_valid(q_valid), .ready(tx_ready), .elapsed(elapsed)
  );

  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !tx_ready)
    else $error("ready still high after frame end");

  a_r6_gap_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_end && $rose(tx_ready)) |-> (elapsed >= PROD_W'(MIN_GAP_BYTES)))
    else $error("gap shorter than minimum");
endmodule

// File: tb/ipg_stretch_bench.sv
`timescale 1ns/1ps
module ipg_stretch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_vld = 1'b0;
  logic        frame_end = 1'b0;
  logic        stretch_en = 1'b0;
  logic        full_duplex = 1'b1;
  logic [15:0] ratio = 16'h0000;
  logic        tx_ready;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ipg_stretch u_ipg_stretch (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .frame_end(frame_end),
    .stretch_en(stretch_en), .full_duplex(full_duplex), .ratio(ratio),
    .tx_ready(tx_ready)
  );

  typedef struct packed {
    logic        en;
    logic        fd;
    logic [15:0] rat;
    int unsigned len;
    int unsigned exp_low;
    int unsigned req;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b0, 1'b1, 16'h0102,   64,  12, 3},  // R3 enable off
    '{1'b1, 1'b0, 16'h0104,   64,  12, 3},  // R3 half duplex
    '{1'b1, 1'b1, 16'h0104,   64, 128, 5},  // R5 64*4/2
    '{1'b1, 1'b1, 16'h0002,   72, 144, 8},  // R8 divide by one
    '{1'b1, 1'b1, 16'h0500,   64,  24, 6},  // R6 zero multiplier, R7 floor
    '{1'b1, 1'b1, 16'h0901,  100,  24, 7},  // R7 10 -> 12 -> 24
    '{1'b1, 1'b1, 16'h0403,  200, 120, 5},  // R5 600/5
    '{1'b1, 1'b1, 16'hFFFF, 1000, 996, 5},  // R5 255000/256
    '{1'b1, 1'b1, 16'h0101,   60,  30, 5},  // R5 60/2
    '{1'b1, 1'b1, 16'h0207,   13,  30, 5}   // R5 91/3
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive a frame of len bytes; frame_end on the last one
  task automatic send_frame(input logic en, input logic fd, input logic [15:0] rat,
                            input int len);
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      if (i == 0) begin
        stretch_en  = en;
        full_duplex = fd;
        ratio       = rat;
      end
      byte_vld  = 1'b1;
      frame_end = (i == len - 1);
    end
    @(posedge clk); #1;
    byte_vld  = 1'b0;
    frame_end = 1'b0;
  endtask

  // count low cycles from the cycle after frame_end; first sample also checks R2
  task automatic measure_low(input string tag, output int low);
    low = 0;
    @(negedge clk);
    check({tag, " R2 drop"}, int'(tx_ready), 0);
    while (!tx_ready && low < 5000) begin
      low++;
      @(negedge clk);
    end
  endtask

  initial begin
    int low;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", int'(tx_ready), 1);

    foreach (VECS[k]) begin
      send_frame(VECS[k].en, VECS[k].fd, VECS[k].rat, int'(VECS[k].len));
      measure_low($sformatf("vector %0d R%0d", k, VECS[k].req), low);
      check($sformatf("vector %0d R%0d gap", k, VECS[k].req), low, int'(VECS[k].exp_low));
    end

    // R4: single-byte frame, strobe coincides with frame_end; 1*100/1
    send_frame(1'b1, 1'b1, 16'h0064, 1);
    measure_low("R4", low);
    check("R4 one-byte frame gap", low, 100);

    // R9: change settings during a running gap
    send_frame(1'b1, 1'b1, 16'h0104, 64);
    low = 0;
    @(negedge clk);
    check("R9 drop", int'(tx_ready), 0);
    for (int j = 0; j < 3; j++) begin
      if (!tx_ready) low++;
      @(negedge clk);
    end
    stretch_en = 1'b0;
    ratio      = 16'h0001;
    while (!tx_ready && low < 5000) begin
      low++;
      @(negedge clk);
    end
    check("R9 gap keeps captured ratio", low, 128);
    send_frame(1'b0, 1'b1, 16'h0001, 64);
    measure_low("R9 next", low);
    check("R9 next gap uses new setting", low, 12);

    // R10: saturated length 65535/256 = 255; wrapped would give 24
    send_frame(1'b1, 1'b1, 16'hFF01, 66000);
    measure_low("R10", low);
    check("R10 saturated length gap", low, 255);

    // R3: fixed mode ignores a large ratio
    send_frame(1'b0, 1'b0, 16'h00FF, 500);
    measure_low("R3 ratio ignored", low);
    check("R3 ratio ignored gap", low, 12);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule